// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Controller

This block is a 32-bit processor core built around one shared internal bus and driven by a hardwired state sequencer. Its datapath holds a program counter, a memory address latch, a memory data latch, an instruction latch, a 32-entry register file, an ALU operand latch (Y) and an ALU result latch (Z). In every control state at most one source drives the bus, and any number of latches may capture it. The ALU always takes Y as its first operand and the bus as its second, and writes into Z.

The core fetches a word, advances the PC by four, and dispatches on the opcode to a short per-instruction sequence. The sequences are:

- lowest-set-bit extraction
- OR with a zero-extended immediate
- register/memory exchange
- multiply-by-four built from two doublings
- two-word absolute jump

Any other opcode sends the machine to a permanent halt. Memory is external. The core issues a one-cycle request, a read or a write, and then stalls in a wait state until the memory raises its completion flag.

States and transitions: reset enters FETCH_ADDR. The fetch path runs FETCH_ADDR → FETCH_WAIT, which loops on itself until completion → FETCH_IR → FETCH_DISPATCH. FETCH_DISPATCH branches on the opcode:

| Opcode | Sequence |
|---|---|
| 1 | LSB_1…LSB_5 |
| 13 | ORI_1…ORI_3 |
| 2 | XCH_1, XCH_2 (waits), XCH_3…XCH_6, XCH_7 (waits), XCH_8 |
| 3 | MUL_1…MUL_5 |
| 4 | JMP_1, JMP_2 (waits), JMP_3 |
| anything else | HALT |

Every instruction sequence returns to FETCH_ADDR. HALT loops on itself.

Top module: `busproc_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the PC is 0 and `halted` is low; that first cycle issues a read request (`mem_req`=1, `mem_we`=0) at address 0.
- R2: An instruction word is fetched from the PC address. The fetch holds in its wait state, with the PC unchanged, until `mem_done` is seen. The PC becomes the fetch address plus 4 at the dispatch step, which is the fifth rising edge after the fetch request when memory completes two cycles after the request.
- R3: Opcode 1 (field [31:26]) writes to register rt ([20:16]) the lowest set bit of register rs ([25:21]), that is rs & (-rs). A zero source gives zero.
- R4: Opcode 13 writes rt = rs OR the zero-extended immediate in [15:0].
- R5: Opcode 2 exchanges register rt with the memory word at the byte address held in rs. Memory receives the old rt and rt receives the old memory word.
- R6: Opcode 3 replaces register rd ([15:11]) with 4·rd modulo 2^32.
- R7: Opcode 4 is two words long. The second word is loaded into the PC, and fetching resumes from that address.
- R8: Any other opcode halts the machine for good. `halted` rises, the PC stays at the address of the undecoded word plus 4, and no further memory requests are issued.
- R9: Register 0 always reads as zero, and writes to it are dropped.
- R10: `mem_req` is high for a single cycle per access, and a request is never both a read and a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | With `mem_req`: 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data (memory data latch) |
| mem_rdata | input | 32 | Read data, valid while `mem_done` is high |
| mem_done | input | 1 | Completion flag for the outstanding access |
| halted | output | 1 | High once the halt state is reached |
| pc_out | output | 32 | Current program counter |

## Verification
The assertions check the following on every cycle:

- the request pulse shape and the read/write exclusion
- that every wait state holds while completion is absent
- that the dispatch step advances the PC by exactly four
- that the PC holds during the fetch stall
- that the halt state is absorbing and silent on the memory side and the register file

Only the bench scenarios can show the arithmetic results of the instruction sequences. These include:

- lowest-set-bit values across random and edge operands
- OR results
- multiply-by-four wraparound after repeated application
- the two directions of the exchange
- the jump target reaching the PC
- register 0 staying zero after a write attempt

The bench reads these results back through memory, using the exchange instruction.

// File: rtl/busproc_pkg.sv
package busproc_pkg;

    typedef enum logic [3:0] {
        SRC_NONE, SRC_PC, SRC_MDR, SRC_Z, SRC_REG, SRC_IMM,
        SRC_C4, SRC_CM1, SRC_C0
    } bus_src_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_XOR, ALU_OR} alu_op_e;

    typedef enum logic [1:0] {FLD_RS, FLD_RT, FLD_RD} reg_fld_e;

    typedef struct packed {
        bus_src_e src;
        logic     mar_ld;
        logic     y_ld;
        logic     z_ld;
        logic     ir_ld;
        logic     pc_ld;
        logic     mdr_ld;
        logic     mdr_mem;
        logic     reg_wr;
        reg_fld_e fld;
        alu_op_e  op;
        logic     mem_rd;
        logic     mem_wr;
    } ctrl_word_t;

    typedef enum logic [4:0] {
        S_FETCH_ADDR, S_FETCH_WAIT, S_FETCH_IR, S_FETCH_DISPATCH,
        S_LSB_1, S_LSB_2, S_LSB_3, S_LSB_4, S_LSB_5,
        S_ORI_1, S_ORI_2, S_ORI_3,
        S_XCH_1, S_XCH_2, S_XCH_3, S_XCH_4, S_XCH_5, S_XCH_6, S_XCH_7, S_XCH_8,
        S_MUL_1, S_MUL_2, S_MUL_3, S_MUL_4, S_MUL_5,
        S_JMP_1, S_JMP_2, S_JMP_3,
        S_HALT
    } state_e;

    localparam int OPC_W = 6;
    localparam logic [OPC_W-1:0] OPC_LSB  = 6'd1;
    localparam logic [OPC_W-1:0] OPC_XCH  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_MUL4 = 6'd3;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;

endpackage

// File: rtl/busproc_alu.sv
module busproc_alu
    import busproc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  alu_op_e       op,
    output logic [DW-1:0] res
);

    always_comb begin
        unique case (op)
            ALU_ADD: res = opa + opb;
            ALU_AND: res = opa & opb;
            ALU_XOR: res = opa ^ opb;
            ALU_OR:  res = opa | opb;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/busproc_regfile.sv
module busproc_regfile #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] bank [NREG];

    assign bank[0] = '0;   // register 0 has no storage

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank[g] <= '0;
            else if (wr_en && sel == AW'(g))
                bank[g] <= wdata;
        end
    end

    assign rdata = bank[sel];

endmodule

// File: rtl/busproc_ctrl.sv
module busproc_ctrl
    import busproc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             mem_done,
    output state_e           st,
    output ctrl_word_t       cw,
    output logic             halted
);

    state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_FETCH_ADDR;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_FETCH_ADDR:     nxt = S_FETCH_WAIT;
            S_FETCH_WAIT:     nxt = mem_done ? S_FETCH_IR : S_FETCH_WAIT;
            S_FETCH_IR:       nxt = S_FETCH_DISPATCH;
            S_FETCH_DISPATCH: begin
                unique case (opcode)
                    OPC_LSB:  nxt = S_LSB_1;
                    OPC_ORI:  nxt = S_ORI_1;
                    OPC_XCH:  nxt = S_XCH_1;
                    OPC_MUL4: nxt = S_MUL_1;
                    OPC_JMP:  nxt = S_JMP_1;
                    default:  nxt = S_HALT;
                endcase
            end
            S_LSB_1: nxt = S_LSB_2;
            S_LSB_2: nxt = S_LSB_3;
            S_LSB_3: nxt = S_LSB_4;
            S_LSB_4: nxt = S_LSB_5;
            S_LSB_5: nxt = S_FETCH_ADDR;
            S_ORI_1: nxt = S_ORI_2;
            S_ORI_2: nxt = S_ORI_3;
            S_ORI_3: nxt = S_FETCH_ADDR;
            S_XCH_1: nxt = S_XCH_2;
            S_XCH_2: nxt = mem_done ? S_XCH_3 : S_XCH_2;
            S_XCH_3: nxt = S_XCH_4;
            S_XCH_4: nxt = S_XCH_5;
            S_XCH_5: nxt = S_XCH_6;
            S_XCH_6: nxt = S_XCH_7;
            S_XCH_7: nxt = mem_done ? S_XCH_8 : S_XCH_7;
            S_XCH_8: nxt = S_FETCH_ADDR;
            S_MUL_1: nxt = S_MUL_2;
            S_MUL_2: nxt = S_MUL_3;
            S_MUL_3: nxt = S_MUL_4;
            S_MUL_4: nxt = S_MUL_5;
            S_MUL_5: nxt = S_FETCH_ADDR;
            S_JMP_1: nxt = S_JMP_2;
            S_JMP_2: nxt = mem_done ? S_JMP_3 : S_JMP_2;
            S_JMP_3: nxt = S_FETCH_ADDR;
            S_HALT:  nxt = S_HALT;
            default: nxt = S_HALT;
        endcase
    end

    // one bus source per state; ALU operand A is always Y
    always_comb begin
        cw = '0;
        unique case (st)
            S_FETCH_ADDR:     begin cw.src = SRC_PC;  cw.mar_ld = 1'b1; cw.mem_rd = 1'b1; cw.y_ld = 1'b1; end
            S_FETCH_WAIT:     begin cw.src = SRC_C4;  cw.op = ALU_ADD; cw.z_ld = 1'b1; cw.mdr_mem = 1'b1; end
            S_FETCH_IR:       begin cw.src = SRC_MDR; cw.ir_ld = 1'b1; end
            S_FETCH_DISPATCH: begin cw.src = SRC_Z;   cw.pc_ld = 1'b1; end
            S_LSB_1: begin cw.src = SRC_REG; cw.fld = FLD_RS; cw.y_ld = 1'b1; end
            S_LSB_2: begin cw.src = SRC_CM1; cw.op = ALU_ADD; cw.z_ld = 1'b1; end
            S_LSB_3: begin cw.src = SRC_Z;   cw.op = ALU_AND; cw.z_ld = 1'b1; end
            S_LSB_4: begin cw.src = SRC_Z;   cw.op = ALU_XOR; cw.z_ld = 1'b1; end
            S_LSB_5: begin cw.src = SRC_Z;   cw.fld = FLD_RT; cw.reg_wr = 1'b1; end
            S_ORI_1: begin cw.src = SRC_REG; cw.fld = FLD_RS; cw.y_ld = 1'b1; end
            S_ORI_2: begin cw.src = SRC_IMM; cw.op = ALU_OR;  cw.z_ld = 1'b1; end
            S_ORI_3: begin cw.src = SRC_Z;   cw.fld = FLD_RT; cw.reg_wr = 1'b1; end
            S_XCH_1: begin cw.src = SRC_REG; cw.fld = FLD_RS; cw.mar_ld = 1'b1; cw.mem_rd = 1'b1; end
            S_XCH_2: begin cw.mdr_mem = 1'b1; end
            S_XCH_3: begin cw.src = SRC_MDR; cw.y_ld = 1'b1; end
            S_XCH_4: begin cw.src = SRC_C0;  cw.op = ALU_ADD; cw.z_ld = 1'b1; end
            S_XCH_5: begin cw.src = SRC_REG; cw.fld = FLD_RT; cw.mdr_ld = 1'b1; end
            S_XCH_6: begin cw.mem_wr = 1'b1; end
            S_XCH_7: begin end
            S_XCH_8: begin cw.src = SRC_Z;   cw.fld = FLD_RT; cw.reg_wr = 1'b1; end
            S_MUL_1: begin cw.src = SRC_REG; cw.fld = FLD_RD; cw.y_ld = 1'b1; end
            S_MUL_2: begin cw.src = SRC_REG; cw.fld = FLD_RD; cw.op = ALU_ADD; cw.z_ld = 1'b1; end
            S_MUL_3: begin cw.src = SRC_Z;   cw.y_ld = 1'b1; end
            S_MUL_4: begin cw.src = SRC_Z;   cw.op = ALU_ADD; cw.z_ld = 1'b1; end
            S_MUL_5: begin cw.src = SRC_Z;   cw.fld = FLD_RD; cw.reg_wr = 1'b1; end
            S_JMP_1: begin cw.src = SRC_PC;  cw.mar_ld = 1'b1; cw.mem_rd = 1'b1; cw.y_ld = 1'b1; end
            S_JMP_2: begin cw.src = SRC_C4;  cw.op = ALU_ADD; cw.z_ld = 1'b1; cw.mdr_mem = 1'b1; end
            S_JMP_3: begin cw.src = SRC_MDR; cw.pc_ld = 1'b1; end
            S_HALT:  begin end
            default: begin end
        endcase
    end

    assign halted = (st == S_HALT);

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_FETCH_WAIT || st == S_XCH_2 || st == S_XCH_7 || st == S_JMP_2) && !mem_done)
        |=> (st == $past(st)));                                            // R2
    AST_HALT_ABSORBS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HALT) |=> (st == S_HALT));                                // R8
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw.mem_rd && cw.mem_wr));                                        // R10

endmodule

// File: rtl/busproc_core.sv
module busproc_core
    import busproc_pkg::*;
#(
    parameter int DW = 32,
    parameter int RAW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_done,
    output logic          halted,
    output logic [DW-1:0] pc_out
);

    localparam int IMM_W = 16;

    state_e        st;
    ctrl_word_t    cw;
    logic [DW-1:0] pc, mar, mdr, ir, yq, zq;
    logic [DW-1:0] bus, alu_res, reg_rd, imm_ext;
    logic [RAW-1:0] reg_sel;

    busproc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (ir[31:26]),
        .mem_done (mem_done),
        .st       (st),
        .cw       (cw),
        .halted   (halted)
    );

    always_comb begin
        unique case (cw.fld)
            FLD_RS:  reg_sel = ir[25:21];
            FLD_RT:  reg_sel = ir[20:16];
            default: reg_sel = ir[15:11];
        endcase
    end

    busproc_regfile #(.DW(DW), .AW(RAW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cw.reg_wr),
        .sel   (reg_sel),
        .wdata (bus),
        .rdata (reg_rd)
    );

    assign imm_ext = {{(DW-IMM_W){1'b0}}, ir[IMM_W-1:0]};

    always_comb begin
        unique case (cw.src)
            SRC_PC:  bus = pc;
            SRC_MDR: bus = mdr;
            SRC_Z:   bus = zq;
            SRC_REG: bus = reg_rd;
            SRC_IMM: bus = imm_ext;
            SRC_C4:  bus = DW'(4);
            SRC_CM1: bus = '1;
            SRC_C0:  bus = '0;
            default: bus = '0;
        endcase
    end

    busproc_alu #(.DW(DW)) u_alu (
        .opa (yq),
        .opb (bus),
        .op  (cw.op),
        .res (alu_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
            mdr <= '0;
            ir  <= '0;
            yq  <= '0;
            zq  <= '0;
        end else begin
            if (cw.pc_ld)  pc  <= bus;
            if (cw.mar_ld) mar <= bus;
            if (cw.ir_ld)  ir  <= bus;
            if (cw.y_ld)   yq  <= bus;
            if (cw.z_ld)   zq  <= alu_res;
            if (cw.mdr_ld)                 mdr <= bus;
            else if (cw.mdr_mem && mem_done) mdr <= mem_rdata;
        end
    end

    // the address latch loads in the same state that requests, so pass the bus through
    assign mem_req   = cw.mem_rd | cw.mem_wr;
    assign mem_we    = cw.mem_wr;
    assign mem_addr  = cw.mar_ld ? bus : mar;
    assign mem_wdata = mdr;
    assign pc_out    = pc;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);                                             // R10
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FETCH_DISPATCH) |=> (pc == $past(pc) + DW'(4)));          // R2
    AST_PC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FETCH_WAIT) |=> $stable(pc));                             // R2
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !cw.reg_wr));                              // R8
    AST_HALT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));                                           // R8

endmodule

// File: tb/busproc_core_bench.sv
`timescale 1ns/1ps
module busproc_core_bench;

    localparam int MW       = 512;
    localparam int RES_BASE = 32'h600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, mem_done, halted;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_out;

    always #10 clk = ~clk;

    busproc_core u_busproc_core (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_done(mem_done), .halted(halted), .pc_out(pc_out)
    );

    // word memory: completion two cycles after the request cycle
    logic [31:0] mem [MW];
    logic [8:0]  addr_q = '0;
    logic        pend = 1'b0;
    logic        prev_req = 1'b0;
    int          req_cnt = 0;
    int          pulse_err = 0;
    logic        ld_en = 1'b0, clr_en = 1'b0;
    int          ld_idx = 0;
    logic [31:0] ld_val = '0;

    initial begin
        mem_done  = 1'b0;
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        mem_done <= 1'b0;
        if (clr_en) begin
            for (int i = 0; i < MW; i++) mem[i] <= '0;
            req_cnt <= 0;
        end else if (ld_en) begin
            mem[ld_idx] <= ld_val;
        end
        if (!rst_n) begin
            pend <= 1'b0;
            prev_req <= 1'b0;
        end else begin
            if (pend) begin
                mem_done  <= 1'b1;
                mem_rdata <= mem[addr_q];
            end
            pend <= 1'b0;
            if (mem_req) begin
                addr_q  <= mem_addr[10:2];
                pend    <= 1'b1;
                req_cnt <= req_cnt + 1;
                if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
                if (prev_req) pulse_err <= pulse_err + 1;
            end
            prev_req <= mem_req;
        end
    end

    int total = 0, bad = 0, pw = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int op, input int rs, input int rt, input int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] exp_lsb(input logic [31:0] v);
        return v & (~v + 32'd1);
    endfunction

    function automatic logic [31:0] exp_mul(input logic [31:0] v, input int k);
        logic [31:0] r = v;
        for (int i = 0; i < k; i++) r = r << 2;
        return r;
    endfunction

    task automatic clear_mem();
        rst_n = 1'b0;
        clr_en = 1'b1;
        @(posedge clk); #1 clr_en = 1'b0;
        pw = 0;
    endtask

    task automatic load(input int idx, input logic [31:0] val);
        ld_idx = idx; ld_val = val; ld_en = 1'b1;
        @(posedge clk); #1 ld_en = 1'b0;
    endtask

    task automatic emit(input logic [31:0] w);
        load(pw, w);
        pw++;
    endtask

    // copy register r into the result slot via an exchange through r21
    task automatic store_reg(input int r, input int slot);
        emit(enc(13, 0, 21, RES_BASE + 4*slot));
        emit(enc(2, 21, r, 0));
    endtask

    function automatic logic [31:0] res_at(input int slot);
        return mem[(RES_BASE >> 2) + slot];
    endfunction

    task automatic run_prog(input string tag);
        int cyc = 0;
        @(negedge clk) rst_n = 1'b1;
        while (!halted && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) begin
            total++; bad++;
            $display("FAIL watchdog %s actual=running expected=halted", tag);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int base;
        logic [31:0] v, b;
        logic [31:0] vals [8];
        int ks [8];
        void'($urandom(32'd2024));

        // R1, R2, R8: reset state, fetch timing, halt on undecoded word 0
        clear_mem();
        @(negedge clk) rst_n = 1'b1;
        check("R1 pc at reset", pc_out, 32'd0);
        check("R1 halted at reset", {31'd0, halted}, 32'd0);
        check("R1 first request", {30'd0, mem_req, mem_we}, 32'd2);
        check("R1 first address", mem_addr, 32'd0);
        repeat (4) @(negedge clk);
        check("R2 pc held during fetch", pc_out, 32'd0);
        @(negedge clk);
        check("R2 pc after dispatch", pc_out, 32'd4);
        check("R8 halted after undecoded", {31'd0, halted}, 32'd1);
        repeat (10) @(negedge clk);
        check("R8 no requests after halt", req_cnt, 1);
        check("R8 pc stays", pc_out, 32'd4);

        // R4, R5: directed OR immediate
        clear_mem();
        emit(enc(13, 0, 9, 5));
        emit(enc(13, 9, 10, 3));
        store_reg(10, 0);
        run_prog("ori");
        check("R4 ori 5|3", res_at(0), 32'd7);
        check("R8 pc after ori prog", pc_out, 4*pw + 4);

        // R5: directed exchange both ways
        clear_mem();
        load(20, 32'd42);
        emit(enc(13, 0, 1, 80));
        emit(enc(13, 0, 2, 601));
        emit(enc(2, 1, 2, 0));
        store_reg(2, 0);
        run_prog("xchg");
        check("R5 memory gets register", mem[20], 32'd601);
        check("R5 register gets memory", res_at(0), 32'd42);

        // R3: lowest set bit, directed edges then random
        for (int batch = 0; batch < 2; batch++) begin
            clear_mem();
            for (int i = 0; i < 8; i++) begin
                if (batch == 0 && i == 0)      vals[i] = 32'h0;
                else if (batch == 0 && i == 1) vals[i] = 32'h8000;
                else if (batch == 0 && i == 2) vals[i] = 32'hFFFF;
                else if (batch == 0 && i == 3) vals[i] = 32'h1;
                else                           vals[i] = {16'd0, 16'($urandom)};
                emit(enc(13, 0, 3, int'(vals[i])));
                emit(enc(1, 3, 4, 0));
                store_reg(4, i);
            end
            run_prog("lsb");
            for (int i = 0; i < 8; i++)
                check($sformatf("R3 lsb of %h", vals[i]), res_at(i), exp_lsb(vals[i]));
        end

        // R4: random OR operands
        clear_mem();
        for (int i = 0; i < 6; i++) begin
            v = {16'd0, 16'($urandom)};
            b = {16'd0, 16'($urandom)};
            vals[i] = v | b;
            emit(enc(13, 0, 7, int'(v)));
            emit(enc(13, 7, 8, int'(b)));
            store_reg(8, i);
        end
        run_prog("ori rnd");
        for (int i = 0; i < 6; i++)
            check("R4 ori random", res_at(i), vals[i]);

        // R6: multiply by four, repeated up to wraparound
        clear_mem();
        for (int i = 0; i < 8; i++) begin
            if (i == 0)      begin vals[i] = 32'd2;    ks[i] = 1; end
            else if (i == 1) begin vals[i] = 32'hFFFF; ks[i] = 9; end
            else if (i == 2) begin vals[i] = 32'h3;    ks[i] = 15; end
            else begin vals[i] = {16'd0, 16'($urandom)}; ks[i] = 1 + int'($urandom % 9); end
            emit(enc(13, 0, 5, int'(vals[i])));
            for (int k = 0; k < ks[i]; k++) emit(enc(3, 0, 0, 5 << 11));
            store_reg(5, i);
        end
        run_prog("mul4");
        for (int i = 0; i < 8; i++)
            check($sformatf("R6 mul4 %h x%0d", vals[i], ks[i]), res_at(i), exp_mul(vals[i], ks[i]));

        // R7: two-word jump, word after jump must not run
        clear_mem();
        emit(32'h1000_0000);
        emit(32'd800);
        emit(enc(13, 0, 6, 16'h1234));
        store_reg(6, 0);
        run_prog("jmp");
        check("R7 pc after jump and halt", pc_out, 32'd804);
        check("R7 skipped words not run", res_at(0), 32'd0);

        // R9: write to register 0 dropped
        clear_mem();
        load((RES_BASE >> 2), 32'hAAAA_5555);
        emit(enc(13, 0, 0, 16'h55));
        store_reg(0, 0);
        run_prog("r0");
        check("R9 register 0 reads zero", res_at(0), 32'd0);

        // R10: request pulses across all runs
        check("R10 back-to-back requests", pulse_err, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog global actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule